// File: doc/BRIEF.md
# Reset Cause and Request Register

This block holds a five-bit record of why the system was last reset, and lets software and board buttons request a new reset. It sits on a simple register port and answers at one 8-byte window. Only the upper word of that window, the one whose address bit 2 is set, carries data. Software reads the cause bits, clears the ones it has handled by writing ones, and starts a soft power-on or soft external reset by writing a one to the matching request bit. Two button inputs record a button power-on or a button external event. Each trigger produces a one-cycle pulse on the reset request output.

Two resets come in. `pwr_rst_i` is the power-up reset of the block itself. `sys_rst_i` is the system reset that the request output normally causes. The cause bits survive a system reset. A saturating counter of system resets decides whether a reset is a "first" reset, and so reloads the power-on cause. A soft power-on request sets that counter back to zero.

Top module: `reset_cause_ctl`

## Requirements
- R1: While `pwr_rst_i` is high at a clock edge, the register becomes 0x80000000 (only the power-on cause, bit 31), the reset counter becomes 1, `rst_req_o` becomes 0 and `bus_rdata_o` becomes 0.
- R2: A read (`bus_rd_i`) at an address whose bits 15:3 equal 0xF020>>3 and whose bit 2 is 1 returns the register one cycle later. The cause bits sit at 31 (power-on), 30 (soft power-on), 29 (soft external), 28 (button power-on) and 27 (button external). Bits 26:0 always read 0, and every other read returns 0.
- R3: Write data is masked with 0xF8000000. A one in bit 31, 28 or 27 of a data-word write clears that register bit.
- R4: A one in bit 30 or 29 of a data-word write sets that register bit. A zero leaves it unchanged.
- R5: A data-word write with bit 30 or bit 29 set pulses `rst_req_o` in the next cycle. A write with bit 30 set also sets the reset counter to 0.
- R6: On a `sys_rst_i` cycle, the register is reloaded with 0x80000000 only if the counter is 0. Otherwise it keeps its value. The counter then increments and saturates at 2^CNT_W-1, so it never wraps back to 0.
- R7: A rising edge on `btn_por_i` or `btn_xir_i` sets bit 28 or bit 27 and pulses `rst_req_o`. A button held high counts once. If a write clears a bit in the same cycle that a button sets it, the button wins.
- R8: `rst_req_o` is never high for two cycles in a row. A trigger in the cycle that follows a pulse merges into that pulse.
- R9: In a `sys_rst_i` cycle, writes and button edges are ignored, the counter is not cleared, and `rst_req_o` is 0 in the following cycle.
- R10: Writes outside the data word change nothing, and with no write, button edge or reset the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| pwr_rst_i | input | 1 | Synchronous power-up reset, active high |
| sys_rst_i | input | 1 | Synchronous system reset, active high; counted |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| btn_por_i | input | 1 | Power-on button level |
| btn_xir_i | input | 1 | External-reset button level |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two events can land in one cycle: a software write that clears cause bits, and a button edge that sets one. A third case is a system reset that arrives together with a write and a button edge. The bench provokes the first by raising a button in the same cycle as a clearing write, and judges it by the read-back value (button set beats the clear) and by a single request pulse. It provokes the second by asserting `sys_rst_i` with a soft power-on write and a button edge, and checks that the register and counter are untouched and no pulse follows. A sweep over all 32×32 pairs of starting cause state and written value also compares the read-back, the pulse and the effect of the next system reset against arithmetic expectations.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned NCAUSE   = 5;
  localparam int unsigned FIELD_LSB = 27;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NBTN     = 2;

  // index inside the 5-bit cause field (field bit 0 = word bit 27)
  localparam int unsigned CI_PWR  = 4;
  localparam int unsigned CI_SPOR = 3;
  localparam int unsigned CI_SXIR = 2;
  localparam int unsigned CI_BPOR = 1;
  localparam int unsigned CI_BXIR = 0;

  // button vector index
  localparam int unsigned BI_XIR = 0;
  localparam int unsigned BI_POR = 1;

  localparam logic [NCAUSE-1:0] CLR_MASK  = 5'b10011;
  localparam logic [NCAUSE-1:0] SET_MASK  = 5'b01100;
  localparam logic [NCAUSE-1:0] FIRST_VAL = 5'b10000;
endpackage

// File: rtl/rstc_addr_dec.sv
module rstc_addr_dec #(
  parameter int unsigned          ADDR_W = 16,
  parameter logic [ADDR_W-1:0]    BASE   = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              data_word_o
);
  localparam int unsigned HI = ADDR_W - 1;

  logic window_hit;
  logic unused_lsb;

  assign window_hit  = (addr_i[HI:3] == BASE[HI:3]);
  assign data_word_o = window_hit & addr_i[2];
  assign unused_lsb  = ^addr_i[1:0];
endmodule

// File: rtl/rstc_btn_edge.sv
module rstc_btn_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         pwr_rst_i,
  input  logic [N-1:0] btn_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_btn
    always_ff @(posedge clk_i) begin
      if (pwr_rst_i) prev_q[g] <= 1'b0;
      else           prev_q[g] <= btn_i[g];
    end
    assign evt_o[g] = btn_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
  import rstc_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              pwr_rst_i,
  input  logic              sys_rst_i,
  input  logic              wr_hit_i,
  input  logic [NCAUSE-1:0] wfield_i,
  input  logic [NBTN-1:0]   btn_evt_i,
  output logic [NCAUSE-1:0] cause_o,
  output logic              trig_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NCAUSE-1:0] cause_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NCAUSE-1:0] clr_bits, set_bits, btn_bits;
  logic              soft_req;

  always_comb begin
    clr_bits = wr_hit_i ? (wfield_i & CLR_MASK) : '0;
    set_bits = wr_hit_i ? (wfield_i & SET_MASK) : '0;
    btn_bits = '0;
    btn_bits[CI_BPOR] = btn_evt_i[BI_POR];
    btn_bits[CI_BXIR] = btn_evt_i[BI_XIR];
  end

  assign soft_req = wr_hit_i & (wfield_i[CI_SPOR] | wfield_i[CI_SXIR]);
  assign trig_o   = ~sys_rst_i & (soft_req | (|btn_evt_i));

  always_ff @(posedge clk_i) begin
    if (pwr_rst_i) begin
      cause_q <= FIRST_VAL;
      cnt_q   <= CNT_ONE;
    end else if (sys_rst_i) begin
      if (cnt_q == '0) cause_q <= FIRST_VAL;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
    end else begin
      cause_q <= (cause_q & ~clr_bits) | set_bits | btn_bits;
      if (wr_hit_i && wfield_i[CI_SPOR]) cnt_q <= '0;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rstc_req_pulse.sv
module rstc_req_pulse (
  input  logic clk_i,
  input  logic pwr_rst_i,
  input  logic sys_rst_i,
  input  logic trig_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i) begin
    if (pwr_rst_i || sys_rst_i) req_q <= 1'b0;
    else                        req_q <= trig_i & ~req_q;
  end

  assign req_o = req_q;
endmodule

// File: rtl/reset_cause_ctl.sv
module reset_cause_ctl
  import rstc_pkg::*;
#(
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'hF020,
  parameter int unsigned       CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              pwr_rst_i,
  input  logic              sys_rst_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic              rst_req_o
);
  localparam int unsigned FIELD_HI = FIELD_LSB + NCAUSE - 1;

  logic              data_word;
  logic [NBTN-1:0]   btn_lvl, btn_evt;
  logic [NCAUSE-1:0] cause_q;
  logic              trig;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wlow;

  assign unused_wlow = ^bus_wdata_i[FIELD_LSB-1:0];

  rstc_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) dec_i (
    .addr_i      (bus_addr_i),
    .data_word_o (data_word)
  );

  always_comb begin
    btn_lvl = '0;
    btn_lvl[BI_POR] = btn_por_i;
    btn_lvl[BI_XIR] = btn_xir_i;
  end

  rstc_btn_edge #(.N(NBTN)) edge_i (
    .clk_i     (clk_i),
    .pwr_rst_i (pwr_rst_i),
    .btn_i     (btn_lvl),
    .evt_o     (btn_evt)
  );

  rstc_cause_reg #(.CNT_W(CNT_W)) cause_i (
    .clk_i     (clk_i),
    .pwr_rst_i (pwr_rst_i),
    .sys_rst_i (sys_rst_i),
    .wr_hit_i  (bus_wr_i & data_word),
    .wfield_i  (bus_wdata_i[FIELD_HI:FIELD_LSB]),
    .btn_evt_i (btn_evt),
    .cause_o   (cause_q),
    .trig_o    (trig)
  );

  rstc_req_pulse pulse_i (
    .clk_i     (clk_i),
    .pwr_rst_i (pwr_rst_i),
    .sys_rst_i (sys_rst_i),
    .trig_i    (trig),
    .req_o     (rst_req_o)
  );

  always_ff @(posedge clk_i) begin
    if (pwr_rst_i)                  rdata_q <= '0;
    else if (bus_rd_i && data_word) rdata_q <= {cause_q, {FIELD_LSB{1'b0}}};
    else                            rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/reset_cause_ctl_chk.sv
module reset_cause_ctl_chk #(
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'hF020
) (
  input logic              clk_i,
  input logic              pwr_rst_i,
  input logic              sys_rst_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              btn_por_i,
  input logic              btn_xir_i,
  input logic              rst_req_o,
  input logic [4:0]        cause_q
);
  logic wr_data;
  assign wr_data = bus_wr_i && (bus_addr_i[ADDR_W-1:2] == {BASE[ADDR_W-1:3], 1'b1});

  assert_first_cause_R1: assert property (@(posedge clk_i)
    pwr_rst_i |=> (cause_q == 5'b10000));

  assert_low_zero_R2: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    bus_rdata_o[26:0] == 27'd0);

  assert_soft_set_R4: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    (wr_data && bus_wdata_i[30] && !sys_rst_i) |=> cause_q[3]);

  assert_soft_pulse_R5: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    (wr_data && (bus_wdata_i[30] || bus_wdata_i[29]) && !sys_rst_i && !rst_req_o) |=> rst_req_o);

  assert_one_cycle_R8: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    rst_req_o |=> !rst_req_o);

  assert_quiet_reset_R9: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    sys_rst_i |=> !rst_req_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    (!sys_rst_i && !wr_data && !btn_por_i && !btn_xir_i) |=> $stable(cause_q));
endmodule

bind reset_cause_ctl reset_cause_ctl_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) chk_i (
  .clk_i       (clk_i),
  .pwr_rst_i   (pwr_rst_i),
  .sys_rst_i   (sys_rst_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .btn_por_i   (btn_por_i),
  .btn_xir_i   (btn_xir_i),
  .rst_req_o   (rst_req_o),
  .cause_q     (cause_q)
);

// File: tb/reset_cause_ctl_tb_top.sv
module reset_cause_ctl_tb_top;
  localparam logic [15:0] DATA_A = 16'hF024;
  localparam logic [15:0] LOW_A  = 16'hF020;

  logic        clk = 1'b0;
  logic        pwr_rst = 1'b1, sys_rst = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bpor = 1'b0, bxir = 1'b0;
  logic        req;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  reset_cause_ctl dut_i (
    .clk_i(clk), .pwr_rst_i(pwr_rst), .sys_rst_i(sys_rst),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .btn_por_i(bpor), .btn_xir_i(bxir), .rst_req_o(req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr = 0; rd = 0; sys_rst = 0; pwr_rst = 0;
    cyc();
  endtask

  task automatic pwr();
    pwr_rst = 1; cyc(); pwr_rst = 0;
  endtask

  task automatic sysr();
    sys_rst = 1; cyc(); sys_rst = 0;
  endtask

  task automatic wr_w(input logic [15:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d; cyc(); wr = 0;
  endtask

  task automatic rd_w(input logic [15:0] a, output logic [31:0] v);
    rd = 1; addr = a; cyc(); v = rdata; rd = 0;
  endtask

  function automatic logic [31:0] wordof(input logic [4:0] f);
    return {f, 27'd0};
  endfunction

  logic [31:0] v;

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(); pwr(); 
    // R1 reset state
    chk("R1 req", {31'd0, req}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rd_w(DATA_A, v); chk("R1 value", v, 32'h8000_0000);
    // R2 other addresses
    rd_w(LOW_A, v);    chk("R2 low word", v, 32'd0);
    rd_w(16'hF028, v); chk("R2 next window", v, 32'd0);
    rd_w(16'h0024, v); chk("R2 far", v, 32'd0);
    // R10 writes outside data word
    wr_w(LOW_A, 32'hFFFF_FFFF);    chk("R10 no pulse low", {31'd0, req}, 32'd0);
    wr_w(16'h7024, 32'hFFFF_FFFF); chk("R10 no pulse far", {31'd0, req}, 32'd0);
    idle();
    rd_w(DATA_A, v); chk("R10 unchanged", v, 32'h8000_0000);

    // R7/R8 held button gives one pulse
    bpor = 1; cyc(); chk("R7 pulse", {31'd0, req}, 32'd1);
    cyc(); chk("R8 no second", {31'd0, req}, 32'd0);
    cyc(); chk("R7 held once", {31'd0, req}, 32'd0);
    bpor = 0; idle();
    rd_w(DATA_A, v); chk("R7 bit28", v, 32'h9000_0000);
    // R7 button beats clear in same cycle
    bxir = 1; wr = 1; addr = DATA_A; wdata = 32'h1800_0000; cyc(); wr = 0; bxir = 0;
    chk("R7 pulse same cycle", {31'd0, req}, 32'd1);
    idle();
    rd_w(DATA_A, v); chk("R7 button wins", v, 32'h8800_0000);

    // R8 merge of back-to-back soft requests
    idle();
    wr_w(DATA_A, 32'h2000_0000); chk("R8 first", {31'd0, req}, 32'd1);
    wr_w(DATA_A, 32'h2000_0000); chk("R8 merged", {31'd0, req}, 32'd0);
    wr_w(DATA_A, 32'h2000_0000); chk("R8 again", {31'd0, req}, 32'd1);

    // R9 system reset ignores same-cycle write and button
    pwr(); wr_w(DATA_A, 32'h8000_0000); idle();
    sys_rst = 1; wr = 1; addr = DATA_A; wdata = 32'h6000_0000; bpor = 1; cyc();
    sys_rst = 0; wr = 0;
    chk("R9 no pulse", {31'd0, req}, 32'd0);
    cyc(); chk("R9 still none", {31'd0, req}, 32'd0);
    bpor = 0; idle();
    rd_w(DATA_A, v); chk("R9 unchanged", v, 32'd0);
    sysr(); rd_w(DATA_A, v); chk("R9 counter kept", v, 32'd0);

    // R6 saturation: counter never returns to zero
    pwr(); wr_w(DATA_A, 32'h8000_0000); idle();
    for (int i = 0; i < 20; i++) begin
      sysr(); rd_w(DATA_A, v); chk("R6 saturate", v, 32'd0);
    end

    // Sweep: start state s, written field w (R2 R3 R4 R5 R6)
    for (int si = 0; si < 32; si++) begin
      for (int wi = 0; wi < 32; wi++) begin
        logic [4:0] s, w, e;
        s = 5'(si); w = 5'(wi);
        pwr();
        if (!s[4]) wr_w(DATA_A, 32'h8000_0000);
        if (s[1]) begin bpor = 1; cyc(); bpor = 0; cyc(); end
        if (s[0]) begin bxir = 1; cyc(); bxir = 0; cyc(); end
        if (s[3] | s[2]) begin wr_w(DATA_A, wordof({1'b0, s[3:2], 2'b00})); idle(); end
        idle();
        rd_w(DATA_A, v); chk("R2 setup", v, wordof(s));
        wr_w(DATA_A, wordof(w) | (27'h5A5_A5A5 ^ 27'(si * 33 + wi)));
        chk("R5 pulse", {31'd0, req}, {31'd0, (w[3] | w[2])});
        e = (s & ~(w & 5'b10011)) | (w & 5'b01100);
        idle();
        rd_w(DATA_A, v); chk("R3 R4 result", v, wordof(e));
        sysr();
        rd_w(DATA_A, v);
        chk("R6 after reset", v, wordof((s[3] | w[3]) ? 5'b10000 : e));
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule